// File: doc/BRIEF.md
# Video capture window cropper

This block sits on a pixel stream from a camera front end. Each input beat carries one pixel, qualified by a valid strobe. It is marked as the first pixel of a frame or as the first pixel of a line. The block keeps only a programmable rectangle of each frame and passes the kept pixels on, one cycle later. It drives its own frame-start and line-start markers, placed on the first pixel it keeps.

Four values set the rectangle: a start column, a start row, an active width and an active height. A sensor frame size clips any part of the rectangle that reaches past the frame edge. Inside the rectangle, the block can drop every other column, every other line, or both, to halve the picture.

Configuration arrives through a small write port into shadow registers. The shadow values are copied into the working set when a frame-start pixel arrives. A frame is therefore never cut with a mix of old and new settings.

Top module: `vid_crop_top`

## Requirements
- R1: After reset the output is idle (out_valid low), and the reset register values let the whole input frame through unchanged: sensor size and active size all ones, control word zero.
- R2: An input pixel at column c and row r is kept when hs <= c <= hs+aw and vs <= r <= vs+ah. Here aw is bits 15:0 and ah is bits 31:16 of the active-size word (address 1), each holding size minus one. hs is bits 28:16 and vs is bits 11:0 of the control word (address 2). A kept pixel appears on out_pix with out_valid exactly one clock after it was accepted.
- R3: A pixel is also dropped when c exceeds bits 15:0 or r exceeds bits 31:16 of the sensor-size word (address 0), each holding size minus one. No pixel beyond the sensor frame is produced.
- R4: With bit 31 of the control word set, only columns where c-hs is even are kept.
- R5: With bit 30 of the control word set, only rows where r-vs is even are kept.
- R6: Register writes go to shadow storage. They take effect from the next input pixel that carries in_sof. A write in the same cycle as such a pixel first applies at the frame start after it.
- R7: out_sol is high on each kept pixel with c equal to hs, which is the first kept pixel of its line. out_sof is high on the kept pixel with c equal to hs and r equal to vs. Both markers are low otherwise.
- R8: Cycles with in_valid low produce no output pixel in the following cycle.
- R9: A write to address 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 sensor size, 1 active size, 2 control |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | First kept pixel of the frame |
| out_sol | output | 1 | First kept pixel of the line |
| out_pix | output | PIX_W | Output pixel value |

## Verification
A register write and a frame-start pixel can land in the same cycle. The rule is that the arriving frame still uses the settings copied at its own start, and the fresh write waits one more frame. The bench provokes this by writing the active size on the same step as the in_sof pixel, and by changing the control word in the middle of a frame. It then compares every output cycle of that frame and the next against a model that keeps separate shadow and working copies of the three words. Clipping at the sensor edge and the first-kept-pixel markers also meet on one pixel when the window starts at the frame border, and random windows with decimation cover these cases.

// File: rtl/vid_crop_pkg.sv
// Shared widths, register map and configuration type for the window cropper.
// Assumes 32-bit configuration words and sizes stored as value minus one.
package vid_crop_pkg;
    localparam int SIZE_W   = 16;   // width of size fields and position counters
    localparam int HOFS_W   = 13;   // start column field width
    localparam int VOFS_W   = 12;   // start row field width
    localparam int HGT_LSB  = 16;   // height field position in size words
    localparam int HOFS_LSB = 16;   // start column position in control word
    localparam int VOFS_LSB = 0;    // start row position in control word
    localparam int HDEC_BIT = 31;   // column halving enable
    localparam int VDEC_BIT = 30;   // line halving enable

    localparam logic [1:0] ADDR_SENS = 2'd0;
    localparam logic [1:0] ADDR_ACT  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef struct packed {
        logic [SIZE_W-1:0] sens_w_m1;
        logic [SIZE_W-1:0] sens_h_m1;
        logic [SIZE_W-1:0] act_w_m1;
        logic [SIZE_W-1:0] act_h_m1;
        logic [HOFS_W-1:0] h_ofs;
        logic [VOFS_W-1:0] v_ofs;
        logic              h_half;
        logic              v_half;
    } crop_cfg_t;

    localparam crop_cfg_t CFG_RST = '{
        {SIZE_W{1'b1}}, {SIZE_W{1'b1}}, {SIZE_W{1'b1}}, {SIZE_W{1'b1}},
        {HOFS_W{1'b0}}, {VOFS_W{1'b0}}, 1'b0, 1'b0};
endpackage

// File: rtl/vid_crop_regs.sv
// Shadow and working configuration. Writes land in the shadow set; the
// working set copies the shadow on every accepted frame-start pixel.
// Assumes the caller selects the shadow set for the frame-start pixel itself.
module vid_crop_regs
    import vid_crop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        frame_start,
    output crop_cfg_t   shadow_cfg,
    output crop_cfg_t   live_cfg
);
    // Capture software writes into the shadow set; unknown addresses drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_cfg <= CFG_RST;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_SENS: begin
                    shadow_cfg.sens_w_m1 <= cfg_wdata[SIZE_W-1:0];
                    shadow_cfg.sens_h_m1 <= cfg_wdata[HGT_LSB +: SIZE_W];
                end
                ADDR_ACT: begin
                    shadow_cfg.act_w_m1 <= cfg_wdata[SIZE_W-1:0];
                    shadow_cfg.act_h_m1 <= cfg_wdata[HGT_LSB +: SIZE_W];
                end
                ADDR_CTRL: begin
                    shadow_cfg.h_ofs  <= cfg_wdata[HOFS_LSB +: HOFS_W];
                    shadow_cfg.v_ofs  <= cfg_wdata[VOFS_LSB +: VOFS_W];
                    shadow_cfg.h_half <= cfg_wdata[HDEC_BIT];
                    shadow_cfg.v_half <= cfg_wdata[VDEC_BIT];
                end
                default: ;
            endcase
        end
    end

    // Copy the shadow set into the working set at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_cfg <= CFG_RST;
        else if (frame_start)
            live_cfg <= shadow_cfg;
    end
endmodule

// File: rtl/vid_crop_pos.sv
// Column and row tracking for the input stream. Gives the position of the
// pixel presented this cycle; counters saturate at their maximum.
// Assumes in_sof marks the first pixel of a frame and has priority over in_sol.
module vid_crop_pos #(
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    output logic [SIZE_W-1:0] cur_col,
    output logic [SIZE_W-1:0] cur_row
);
    localparam logic [SIZE_W-1:0] CNT_MAX = {SIZE_W{1'b1}};

    logic [SIZE_W-1:0] col_q;
    logic [SIZE_W-1:0] row_q;

    // Position of the pixel on the inputs now, from the last accepted one.
    always_comb begin
        if (in_sof) begin
            cur_col = '0;
            cur_row = '0;
        end else if (in_sol) begin
            cur_col = '0;
            cur_row = (row_q == CNT_MAX) ? CNT_MAX : row_q + 1'b1;
        end else begin
            cur_col = (col_q == CNT_MAX) ? CNT_MAX : col_q + 1'b1;
            cur_row = row_q;
        end
    end

    // Remember the position of the last accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (in_valid) begin
            col_q <= cur_col;
            row_q <= cur_row;
        end
    end
endmodule

// File: rtl/vid_crop_sel.sv
// Keep/drop decision and the registered output stage. A pixel is kept when
// it lies in the window, inside the sensor frame and on a kept phase of the
// optional halving. Markers go on the first kept column and row.
// Assumes cur_col/cur_row describe the pixel on the inputs this cycle.
module vid_crop_sel
    import vid_crop_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [SIZE_W-1:0] cur_col,
    input  logic [SIZE_W-1:0] cur_row,
    input  crop_cfg_t         shadow_cfg,
    input  crop_cfg_t         live_cfg,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_sol,
    output logic [PIX_W-1:0]  out_pix
);
    crop_cfg_t         eff;
    logic [SIZE_W-1:0] h_start, v_start, dcol, drow;
    logic              col_ok, row_ok, keep;

    // Settings for this pixel: a frame-start pixel already uses the shadow.
    always_comb eff = in_sof ? shadow_cfg : live_cfg;

    // Offsets inside the window and the per-axis keep conditions.
    always_comb begin
        h_start = SIZE_W'(eff.h_ofs);
        v_start = SIZE_W'(eff.v_ofs);
        dcol    = cur_col - h_start;
        drow    = cur_row - v_start;
        col_ok  = (cur_col >= h_start) && (dcol <= eff.act_w_m1) &&
                  (cur_col <= eff.sens_w_m1) && !(eff.h_half && dcol[0]);
        row_ok  = (cur_row >= v_start) && (drow <= eff.act_h_m1) &&
                  (cur_row <= eff.sens_h_m1) && !(eff.v_half && drow[0]);
        keep    = in_valid && col_ok && row_ok;
    end

    // Register the kept pixel and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= keep;
            out_sol   <= keep && (dcol == '0);
            out_sof   <= keep && (dcol == '0) && (drow == '0);
            if (keep)
                out_pix <= in_pix;
        end
    end
endmodule

// File: rtl/vid_crop_top.sv
// Window cropper top: register block, position tracker and selector.
// Output lags the accepted input pixel by one clock.
module vid_crop_top
    import vid_crop_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_sol,
    output logic [PIX_W-1:0] out_pix
);
    crop_cfg_t         shadow_cfg, live_cfg;
    logic [SIZE_W-1:0] cur_col, cur_row;
    logic              frame_start;

    // Frame start is an accepted pixel carrying the frame marker.
    always_comb frame_start = in_valid && in_sof;

    vid_crop_regs i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .shadow_cfg(shadow_cfg), .live_cfg(live_cfg)
    );

    vid_crop_pos #(.SIZE_W(SIZE_W)) i_pos (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .cur_col(cur_col), .cur_row(cur_row)
    );

    vid_crop_sel #(.PIX_W(PIX_W)) i_sel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_pix(in_pix), .cur_col(cur_col), .cur_row(cur_row),
        .shadow_cfg(shadow_cfg), .live_cfg(live_cfg),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_pix(out_pix)
    );
endmodule

// File: rtl/vid_crop_chk.sv
// Protocol checker for the cropper output, bound to the top module.
module vid_crop_chk #(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_sol,
    input logic [PIX_W-1:0] out_pix
);
    // R7
    sof_within_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_sol);
    // R7
    marker_with_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);
    // R8
    output_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R2
    pixel_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pix == $past(in_pix)));
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);
endmodule

bind vid_crop_top vid_crop_chk #(.PIX_W(PIX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_pix(out_pix)
);

// File: tb/test_vid_crop_top.sv
module test_vid_crop_top;
    localparam int PIX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_we;
    logic [1:0]       cfg_addr;
    logic [31:0]      cfg_wdata;
    logic             in_valid, in_sof, in_sol;
    logic [PIX_W-1:0] in_pix;
    logic             out_valid, out_sof, out_sol;
    logic [PIX_W-1:0] out_pix;

    vid_crop_top #(.PIX_W(PIX_W)) i_vid_crop_top (.*);

    always #2 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Model: shadow and working copies of the three words.
    logic [31:0] s_sens, s_act, s_ctrl, l_sens, l_act, l_ctrl;
    int m_col, m_row;
    bit armed, e_v, e_sof, e_sol, e_idle;
    logic [PIX_W-1:0] e_pix;
    string e_tag;

    function automatic logic [31:0] size_word(int w, int h);
        return {16'(h - 1), 16'(w - 1)};
    endfunction

    function automatic logic [31:0] ctrl_word(int hs, int vs, bit hd, bit vd);
        return {hd, vd, 1'b0, 13'(hs), 4'b0, 12'(vs)};
    endfunction

    task automatic check_prev();
        bit bad = 0;
        if (!armed) return;
        vectors++;
        if (out_valid !== e_v) begin
            $display("FAIL %s: out_valid=%0b expected %0b", e_idle ? "R8" : e_tag, out_valid, e_v);
            bad = 1;
        end
        if (e_v && out_pix !== e_pix) begin
            $display("FAIL %s: out_pix=%0h expected %0h", e_tag, out_pix, e_pix);
            bad = 1;
        end
        if (out_sol !== e_sol || out_sof !== e_sof) begin
            $display("FAIL R7: sol/sof=%0b%0b expected %0b%0b", out_sol, out_sof, e_sol, e_sof);
            bad = 1;
        end
        if (bad) errors++;
    endtask

    task automatic step(bit v, bit sf, bit sl, logic [PIX_W-1:0] px,
                        bit we, logic [1:0] a, logic [31:0] d, string tag);
        logic [31:0] sn, ac, ct;
        int hs, vs, dc, dr;
        bit kc, kr;
        @(negedge clk);
        check_prev();
        sn = l_sens; ac = l_act; ct = l_ctrl;
        if (v && sf) begin
            sn = s_sens; ac = s_act; ct = s_ctrl;
            l_sens = s_sens; l_act = s_act; l_ctrl = s_ctrl;
        end
        if (v) begin
            if (sf) begin m_col = 0; m_row = 0; end
            else if (sl) begin m_col = 0; m_row++; end
            else m_col++;
        end
        hs = int'(ct[28:16]); vs = int'(ct[11:0]);
        dc = m_col - hs; dr = m_row - vs;
        kc = dc >= 0 && dc <= int'(ac[15:0]) && m_col <= int'(sn[15:0]) && !(ct[31] && dc[0]);
        kr = dr >= 0 && dr <= int'(ac[31:16]) && m_row <= int'(sn[31:16]) && !(ct[30] && dr[0]);
        e_v = v && kc && kr;
        e_sol = e_v && dc == 0;
        e_sof = e_sol && dr == 0;
        e_pix = px;
        e_idle = !v;
        e_tag = tag;
        armed = 1;
        if (we) case (a)
            2'd0: s_sens = d;
            2'd1: s_act  = d;
            2'd2: s_ctrl = d;
            default: ;
        endcase
        in_valid = v; in_sof = sf; in_sol = sl; in_pix = px;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
        step(0, 0, 0, '0, 1, a, d, tag);
    endtask

    task automatic send_frame(int w, int h, int gap, string tag,
                              int wr_at = -1, logic [1:0] wa = 0, logic [31:0] wd = 0);
        int k = 0;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                while (gap > 0 && ($urandom % 100) < gap)
                    step(0, 0, 0, '0, 0, 0, 0, tag);
                step(1, r == 0 && c == 0, c == 0, PIX_W'($urandom), k == wr_at, wa, wd, tag);
                k++;
            end
        end
        step(0, 0, 0, '0, 0, 0, 0, tag);
        step(0, 0, 0, '0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog: run did not complete, expected completion");
        errors++;
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        in_valid = 0; in_sof = 0; in_sol = 0; in_pix = 0;
        s_sens = '1; s_act = '1; s_ctrl = '0;
        l_sens = '1; l_act = '1; l_ctrl = '0;
        m_col = 0; m_row = 0; armed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin
            $display("FAIL R1: out_valid=%0b expected 0 after reset", out_valid);
            errors++;
        end
        // R1: defaults pass the whole frame
        send_frame(6, 4, 20, "R1");
        // R2: plain window inside sensor
        wr(2'd0, size_word(12, 8), "R2");
        wr(2'd1, size_word(5, 3), "R2");
        wr(2'd2, ctrl_word(3, 2, 0, 0), "R2");
        send_frame(12, 8, 25, "R2");
        send_frame(12, 8, 0, "R2");
        // R3: window reaches past sensor edge, input larger than sensor
        wr(2'd0, size_word(8, 6), "R3");
        wr(2'd1, size_word(6, 6), "R3");
        wr(2'd2, ctrl_word(5, 3, 0, 0), "R3");
        send_frame(10, 8, 10, "R3");
        // R4: column halving
        wr(2'd0, size_word(16, 8), "R4");
        wr(2'd1, size_word(9, 4), "R4");
        wr(2'd2, ctrl_word(2, 1, 1, 0), "R4");
        send_frame(14, 7, 10, "R4");
        // R5: line halving, then both
        wr(2'd2, ctrl_word(1, 1, 0, 1), "R5");
        send_frame(14, 7, 10, "R5");
        wr(2'd2, ctrl_word(0, 0, 1, 1), "R5");
        send_frame(14, 7, 0, "R5");
        // R6: mid-frame control write, then write on the frame-start pixel
        wr(2'd0, size_word(20, 10), "R6");
        wr(2'd1, size_word(4, 4), "R6");
        wr(2'd2, ctrl_word(0, 0, 0, 0), "R6");
        send_frame(8, 6, 0, "R6", 10, 2'd2, ctrl_word(2, 1, 0, 0));
        send_frame(8, 6, 0, "R6", 0, 2'd1, size_word(3, 2));
        send_frame(8, 6, 15, "R6");
        // R9: write to unused address changes nothing
        wr(2'd3, 32'hFFFF_FFFF, "R9");
        send_frame(8, 6, 0, "R9");
        // R2: random windows with random halving
        for (int i = 0; i < 20; i++) begin
            int w = 4 + int'($urandom % 17);
            int h = 3 + int'($urandom % 8);
            wr(2'd0, size_word(2 + int'($urandom % 23), 2 + int'($urandom % 10)), "R2");
            wr(2'd1, size_word(1 + int'($urandom % 16), 1 + int'($urandom % 9)), "R2");
            wr(2'd2, ctrl_word(int'($urandom % 9), int'($urandom % 6),
                               1'($urandom), 1'($urandom)), "R2");
            send_frame(w, h, 20, "R2");
            send_frame(w, h, 0, "R2");
        end
        step(0, 0, 0, '0, 0, 0, 0, "R8");
        step(0, 0, 0, '0, 0, 0, 0, "R8");
        finish_run();
    end
endmodule